// File: doc/BRIEF.md
# Nibble-Split Byte DRAM Sequencer

This block lets a byte-wide processor read and write a DRAM array that is only four bits wide. Four memory devices each hold two bits of every byte. A single byte is therefore stored as two nibbles in two neighbouring columns of one row. For each byte request the sequencer opens the row once. It then strobes the two columns one after the other, all inside one 500 ns processor cycle of eight 16 MHz slots. On reads it joins the two nibbles into a byte. On writes it drives each half of the byte in its own column strobe.

The block runs on the 16 MHz master clock. A free-running slot counter marks the eight slots of each processor cycle. The request side is a valid/ready stream. `req_ready` is high only in the last slot of each processor cycle, and a request is taken on the edge where `req_valid` and `req_ready` are both high. A requester that sees `req_ready` low must hold `req_valid` and its fields stable until the next acceptance; nothing is lost while it waits. The result side is a plain one-slot `done` pulse with the read byte on `rdata`.

Top module: `nib_dram_seq`

## Requirements
- R1: While reset is asserted and after it is released, all DRAM strobes are high (inactive), `dram_dq_oe` and `done` are low, and the slot counter starts at slot 0, so the first `req_ready` appears in the eighth slot after release.
- R2: `req_ready` is high in exactly one slot of every eight (slot 7). A request is accepted only when `req_valid` and `req_ready` are both high. A held request starts no DRAM activity before it is accepted.
- R3: An accepted access keeps `dram_ras_n` low in slots 0 to 6 of the following processor cycle and high in slot 7, which is the row precharge slot.
- R4: `dram_cas_n` is low in slots 2, 3, 5 and 6 and high otherwise, giving two column strobes with a precharge slot (4) between them. The address is stable on every falling edge of `dram_cas_n`.
- R5: `dram_addr` carries the row `req_addr[2*MA_W-2:MA_W-1]` in slot 0. It carries the column `{req_addr[MA_W-2:0],0}` in slots 1 to 3 and `{req_addr[MA_W-2:0],1}` in slots 4 to 6.
- R6: On reads, `dram_dq_in` is sampled at the end of slot 3 into `rdata[3:0]` and at the end of slot 6 into `rdata[7:4]`. The byte is valid in slot 7. A write leaves `rdata` unchanged.
- R7: On writes, `dram_we_n` is low and `dram_dq_oe` high in slots 1 to 6, so both go active a slot before each CAS fall. `dram_dq_out` equals `req_wdata[3:0]` in slots 1 to 3 and `req_wdata[7:4]` in slots 4 to 6.
- R8: On reads, `dram_we_n` stays high and `dram_dq_oe` stays low for the whole access.
- R9: `done` is high for exactly slot 7 of each access and never in a processor cycle without an access.
- R10: A request accepted in slot 7 of a running access starts in the very next slot. The row is precharged for exactly one slot between the two accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 16 MHz master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this slot (slot 7) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 2*MA_W-1 | Byte address |
| req_wdata | input | 8 | Write byte |
| done | output | 1 | One-slot completion pulse |
| rdata | output | 8 | Assembled read byte |
| dram_addr | output | MA_W | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_dq_out | output | 4 | Nibble driven to the DRAM |
| dram_dq_oe | output | 1 | Output enable for the nibble bus |
| dram_dq_in | input | 4 | Nibble read from the DRAM |

## Verification
The bench builds the block with the default `MA_W` of 8, so a byte address is 15 bits. It uses the all-zero and all-ones addresses to reach both ends of the row field and the column field, including the nibble-select bit on top of a full column. Distinct nibble patterns in each half make a swapped or duplicated nibble show up on `rdata` and `dram_dq_out`. A back-to-back pair and a held request exercise the one-slot precharge and the stall behaviour.

// File: rtl/nds_pkg.sv
package nds_pkg;
  localparam int SLOTS  = 8;
  localparam int PH_W   = $clog2(SLOTS);
  localparam int NIB_W  = 4;
  localparam int BYTE_W = 8;
  localparam int NIBS   = BYTE_W / NIB_W;

  localparam logic [PH_W-1:0] SL_ROW    = PH_W'(0);
  localparam logic [PH_W-1:0] SL_C0_SET = PH_W'(1);
  localparam logic [PH_W-1:0] SL_C0_LO  = PH_W'(2);
  localparam logic [PH_W-1:0] SL_C0_END = PH_W'(3);
  localparam logic [PH_W-1:0] SL_C1_SET = PH_W'(4);
  localparam logic [PH_W-1:0] SL_C1_LO  = PH_W'(5);
  localparam logic [PH_W-1:0] SL_C1_END = PH_W'(6);
  localparam logic [PH_W-1:0] SL_LAST   = PH_W'(SLOTS-1);

  typedef enum logic [1:0] {ASEL_ROW, ASEL_COL0, ASEL_COL1} asel_e;

  typedef struct packed {
    logic  ras_n;
    logic  cas_n;
    logic  we_n;
    logic  dq_oe;
    logic  done;
    asel_e asel;
  } strobe_t;
endpackage

// File: rtl/nds_phase.sv
module nds_phase
  import nds_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  output logic [PH_W-1:0] ph_q,
  output logic [PH_W-1:0] ph_n,
  output logic            last
);
  assign last = (ph_q == SL_LAST);
  assign ph_n = last ? '0 : ph_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_n;
  end
endmodule

// File: rtl/nds_slot_decode.sv
module nds_slot_decode
  import nds_pkg::*;
(
  input  logic [PH_W-1:0] ph,
  input  logic            act,
  input  logic            wr,
  output strobe_t         st
);
  always_comb begin
    st.ras_n = 1'b1;
    st.cas_n = 1'b1;
    st.we_n  = 1'b1;
    st.dq_oe = 1'b0;
    st.done  = 1'b0;
    st.asel  = ASEL_ROW;
    if (act) begin
      case (ph)
        SL_ROW: begin
          st.ras_n = 1'b0;
        end
        SL_C0_SET, SL_C0_LO, SL_C0_END: begin
          st.ras_n = 1'b0;
          st.asel  = ASEL_COL0;
          st.we_n  = ~wr;
          st.dq_oe = wr;
          st.cas_n = (ph == SL_C0_SET);
        end
        SL_C1_SET, SL_C1_LO, SL_C1_END: begin
          st.ras_n = 1'b0;
          st.asel  = ASEL_COL1;
          st.we_n  = ~wr;
          st.dq_oe = wr;
          st.cas_n = (ph == SL_C1_SET);
        end
        default: begin
          st.done = 1'b1;
          st.asel = ASEL_COL1;
        end
      endcase
    end
  end
endmodule

// File: rtl/nds_nibble_path.sv
module nds_nibble_path
  import nds_pkg::*;
#(
  parameter int MA_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2*MA_W-2:0]   addr,
  input  logic [BYTE_W-1:0]   wdata,
  input  asel_e               asel,
  input  logic [NIB_W-1:0]    dq_in,
  input  logic [NIBS-1:0]     cap,
  output logic [MA_W-1:0]     ma,
  output logic [NIB_W-1:0]    dq_out,
  output logic [BYTE_W-1:0]   rdata
);
  localparam int AW = 2*MA_W - 1;

  logic [MA_W-1:0] row;
  logic [MA_W-2:0] colb;

  assign row  = addr[AW-1 -: MA_W];
  assign colb = addr[MA_W-2:0];

  always_comb begin
    case (asel)
      ASEL_ROW:  ma = row;
      ASEL_COL0: ma = {colb, 1'b0};
      default:   ma = {colb, 1'b1};
    endcase
  end

  assign dq_out = (asel == ASEL_COL1) ? wdata[2*NIB_W-1:NIB_W] : wdata[NIB_W-1:0];

  for (genvar g = 0; g < NIBS; g++) begin : g_cap
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rdata[g*NIB_W +: NIB_W] <= '0;
      else if (cap[g]) rdata[g*NIB_W +: NIB_W] <= dq_in;
    end
  end
endmodule

// File: rtl/nib_dram_seq.sv
module nib_dram_seq
  import nds_pkg::*;
#(
  parameter int MA_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [2*MA_W-2:0]   req_addr,
  input  logic [7:0]          req_wdata,
  output logic                done,
  output logic [7:0]          rdata,
  output logic [MA_W-1:0]     dram_addr,
  output logic                dram_ras_n,
  output logic                dram_cas_n,
  output logic                dram_we_n,
  output logic [3:0]          dram_dq_out,
  output logic                dram_dq_oe,
  input  logic [3:0]          dram_dq_in
);
  localparam int AW = 2*MA_W - 1;

  logic [PH_W-1:0]   ph_q, ph_n;
  logic              last, accept;
  logic              act_q, act_n, wr_q, wr_n;
  logic [AW-1:0]     addr_q, addr_n;
  logic [BYTE_W-1:0] wdata_q, wdata_n;
  strobe_t           st_n;
  logic [MA_W-1:0]   ma_n, ma_q;
  logic [NIB_W-1:0]  dqo_n, dqo_q;
  logic [NIBS-1:0]   cap;
  logic              ras_q, cas_q, we_q, oe_q, done_q;

  nds_phase u_phase (
    .clk (clk), .rst_n (rst_n), .ph_q (ph_q), .ph_n (ph_n), .last (last)
  );

  assign req_ready = last;
  assign accept    = req_valid & last;
  assign act_n     = last ? accept : act_q;
  assign wr_n      = accept ? req_write : wr_q;
  assign addr_n    = accept ? req_addr  : addr_q;
  assign wdata_n   = accept ? req_wdata : wdata_q;

  nds_slot_decode u_dec (
    .ph (ph_n), .act (act_n), .wr (wr_n), .st (st_n)
  );

  assign cap[0] = act_q & ~wr_q & (ph_q == SL_C0_END);
  assign cap[1] = act_q & ~wr_q & (ph_q == SL_C1_END);

  nds_nibble_path #(.MA_W(MA_W)) u_path (
    .clk (clk), .rst_n (rst_n), .addr (addr_n), .wdata (wdata_n),
    .asel (st_n.asel), .dq_in (dram_dq_in), .cap (cap),
    .ma (ma_n), .dq_out (dqo_n), .rdata (rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      ras_q   <= 1'b1;
      cas_q   <= 1'b1;
      we_q    <= 1'b1;
      oe_q    <= 1'b0;
      done_q  <= 1'b0;
      ma_q    <= '0;
      dqo_q   <= '0;
    end else begin
      act_q   <= act_n;
      wr_q    <= wr_n;
      addr_q  <= addr_n;
      wdata_q <= wdata_n;
      ras_q   <= st_n.ras_n;
      cas_q   <= st_n.cas_n;
      we_q    <= st_n.we_n;
      oe_q    <= st_n.dq_oe;
      done_q  <= st_n.done;
      if (act_n) ma_q <= ma_n;
      dqo_q   <= dqo_n;
    end
  end

  assign dram_addr   = ma_q;
  assign dram_ras_n  = ras_q;
  assign dram_cas_n  = cas_q;
  assign dram_we_n   = we_q;
  assign dram_dq_oe  = oe_q;
  assign dram_dq_out = dqo_q;
  assign done        = done_q;
endmodule

// File: rtl/nds_checker.sv
module nds_checker #(
  parameter int MA_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            done,
  input logic [MA_W-1:0] dram_addr,
  input logic            dram_ras_n,
  input logic            dram_cas_n,
  input logic            dram_we_n,
  input logic            dram_dq_oe
);
  a_r2_ready_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> !req_ready);
  a_r2_ras_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_ras_n) |-> $past(req_valid && req_ready));
  a_r4_cas_inside_ras: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_cas_n |-> !dram_ras_n);
  a_r4_addr_stable_at_cas: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_cas_n) |-> $stable(dram_addr));
  a_r7_we_inside_ras: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_we_n |-> !dram_ras_n);
  a_r7_oe_with_we: assert property (@(posedge clk) disable iff (!rst_n)
    dram_dq_oe |-> !dram_we_n);
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r9_done_in_precharge: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> dram_ras_n);
endmodule

bind nib_dram_seq nds_checker #(.MA_W(MA_W)) u_chk (
  .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_ready (req_ready),
  .done (done), .dram_addr (dram_addr), .dram_ras_n (dram_ras_n),
  .dram_cas_n (dram_cas_n), .dram_we_n (dram_we_n), .dram_dq_oe (dram_dq_oe)
);

// File: tb/nib_dram_seq_tb.sv
`timescale 1ns/100ps
module nib_dram_seq_tb;
  localparam real CLK_PERIOD = 62.5;
  localparam int  MA_W = 8;
  localparam int  AW   = 2*MA_W - 1;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            req_valid = 1'b0;
  logic            req_ready;
  logic            req_write = 1'b0;
  logic [AW-1:0]   req_addr = '0;
  logic [7:0]      req_wdata = '0;
  logic            done;
  logic [7:0]      rdata;
  logic [MA_W-1:0] dram_addr;
  logic            dram_ras_n, dram_cas_n, dram_we_n, dram_dq_oe;
  logic [3:0]      dram_dq_out;
  logic [3:0]      dram_dq_in = '0;

  int   checks = 0;
  int   errors = 0;
  logic [7:0] last_rd = 8'h00;

  nib_dram_seq #(.MA_W(MA_W)) u_dut (
    .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_ready (req_ready),
    .req_write (req_write), .req_addr (req_addr), .req_wdata (req_wdata),
    .done (done), .rdata (rdata), .dram_addr (dram_addr),
    .dram_ras_n (dram_ras_n), .dram_cas_n (dram_cas_n), .dram_we_n (dram_we_n),
    .dram_dq_out (dram_dq_out), .dram_dq_oe (dram_dq_oe), .dram_dq_in (dram_dq_in)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // R1: reset state and first ready timing
  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(dram_ras_n && dram_cas_n && dram_we_n, "R1 strobes in reset", 0, 1);
    chk(!dram_dq_oe && !done, "R1 oe/done in reset", 1, 0);
    rst_n = 1'b1;
    chk(req_ready == 1'b0, "R1 ready at slot0", req_ready, 0);
    for (int i = 1; i < 8; i++) begin
      @(negedge clk);
      chk(req_ready == (i == 7), "R1 first ready slot", req_ready, (i == 7));
      chk(dram_ras_n == 1'b1, "R1 ras idle", dram_ras_n, 1);
    end
  endtask

  // one access with per-slot checks (R2..R9)
  task automatic access(input bit wr, input logic [AW-1:0] a,
                        input logic [7:0] wd, input logic [7:0] rd);
    logic [MA_W-1:0] row, c0, c1, ea;
    row = a[AW-1 -: MA_W];
    c0  = {a[MA_W-2:0], 1'b0};
    c1  = {a[MA_W-2:0], 1'b1};
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (k == 0) req_valid = 1'b0;
      if (k == 1) dram_dq_in = rd[3:0];
      if (k == 4) dram_dq_in = rd[7:4];
      chk(req_ready == (k == 7), "R2 ready slot", req_ready, (k == 7));
      chk(dram_ras_n == (k == 7), "R3 ras_n", dram_ras_n, (k == 7));
      chk(dram_cas_n == !(k inside {2, 3, 5, 6}), "R4 cas_n", dram_cas_n,
          !(k inside {2, 3, 5, 6}));
      if (k < 7) begin
        ea = (k == 0) ? row : ((k < 4) ? c0 : c1);
        chk(dram_addr == ea, "R5 dram_addr", dram_addr, ea);
      end
      if (wr) begin
        chk(dram_we_n == !(k >= 1 && k <= 6), "R7 we_n", dram_we_n, !(k >= 1 && k <= 6));
        chk(dram_dq_oe == (k >= 1 && k <= 6), "R7 dq_oe", dram_dq_oe, (k >= 1 && k <= 6));
        if (k >= 1 && k <= 3) chk(dram_dq_out == wd[3:0], "R7 low nibble", dram_dq_out, wd[3:0]);
        if (k >= 4 && k <= 6) chk(dram_dq_out == wd[7:4], "R7 high nibble", dram_dq_out, wd[7:4]);
      end else begin
        chk(dram_we_n == 1'b1, "R8 we_n read", dram_we_n, 1);
        chk(dram_dq_oe == 1'b0, "R8 oe read", dram_dq_oe, 0);
      end
      chk(done == (k == 7), "R9 done", done, (k == 7));
      if (k == 7) begin
        if (!wr) last_rd = rd;
        chk(rdata == last_rd, "R6 rdata", rdata, last_rd);
      end
    end
  endtask

  // R9/R2: a processor cycle with no request stays quiet
  task automatic t_idle();
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      chk(dram_ras_n && dram_cas_n && dram_we_n && !dram_dq_oe, "R2 idle strobes", 0, 1);
      chk(done == 1'b0, "R9 no done idle", done, 0);
    end
  endtask

  // R2: request held while ready is low starts nothing until accepted
  task automatic t_hold();
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 15'h2AD3; req_wdata = 8'hC7;
    for (int k = 1; k < 7; k++) begin
      @(negedge clk);
      chk(dram_ras_n == 1'b1, "R2 held no ras", dram_ras_n, 1);
      chk(req_ready == 1'b0, "R2 held ready low", req_ready, 0);
    end
    @(negedge clk);
    access(1'b1, 15'h2AD3, 8'hC7, 8'h00);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
  end

  initial begin
    t_reset();
    access(1'b0, 15'h0000, 8'h00, 8'hA5);   // R6 read, low address ends
    access(1'b0, 15'h7FFF, 8'h00, 8'h3C);   // R5 all-ones row/column
    access(1'b1, 15'h1234, 8'h96, 8'h00);   // R7 write, R6 rdata kept
    t_idle();
    access(1'b0, 15'h0081, 8'h00, 8'h5E);   // R10 back-to-back chain
    access(1'b1, 15'h0081, 8'hF0, 8'h00);
    access(1'b0, 15'h4000, 8'h00, 8'h1E);
    t_hold();
    t_idle();
    summary();
  end
endmodule